// File: doc/BRIEF.md
# Programmable Trigger and Priority Interrupt Controller

This block collects a vector of raw interrupt lines for one processor and presents a single request line to it. Each source has a two-bit trigger mode that selects one of four kinds of sensitivity: high level, low level, rising edge or falling edge. Each source also has an eight-bit priority. Both settings live in packed configuration words behind a 32-bit register interface. Software turns a source on or off by writing that source's number to one of two command registers.

The processor services interrupts through a claim and complete handshake. A read of the claim register returns the number of the most urgent request and marks that source as in service. A write of the number to the completion register ends the service. A source that is in service is left out of arbitration until it is completed. Edge-mode sources keep a pending latch, so a short pulse is not lost. Level-mode sources request for as long as their synchronized input is at the active level.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every source is disabled, has trigger mode 0 and priority 0, and is neither pending nor in service. `irq_o` is low, and every configuration word and the enable bitmap read as zero.
- R2: The trigger words start at offset 0x100, one word per sixteen sources. Source i uses bits [(2i mod 32)+1 : 2i mod 32] of word i/16. The codes are 0 for active-high level, 1 for active-low level, 2 for rising edge and 3 for falling edge. A word reads back as written. Bits that belong to no source read as 0. A write to one word leaves every other word unchanged.
- R3: The priority words start at offset 0x200, one word per four sources. Source i uses bits [(8i mod 32)+7 : 8i mod 32] of word i/4. Each field takes a value from 0 to 255. A word reads back as written, and a write to one word leaves every other word unchanged.
- R4: Writing a source number to offset 0x000 enables that source, and writing it to offset 0x004 disables it. Numbers at or above the source count are ignored. A read of offset 0x000 returns the enable bitmap, with bit i for source i.
- R5: Inputs pass through a two-stage synchronizer. A level-mode request appears on `irq_o` after the second clock edge that follows the input change. An edge-mode source latches a pending bit on its selected edge, and the bit stays set after the input returns. An edge of the other direction, or a level that holds steady, sets nothing.
- R6: A read of offset 0x008 returns the number of the requesting source with the smallest priority value. On a tie, the lower source number wins. Read data and `bus_rvalid` appear in the cycle after the read.
- R7: A claimed source is in service and is not returned again until its number is written to offset 0x00C. Claiming an edge-mode source clears its pending bit.
- R8: A read of offset 0x008 while nothing is requesting returns 0xFFFFFFFF and changes no state.
- R9: `irq_o` is high exactly when some source is enabled, not in service, and requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_SRC | Raw interrupt inputs, asynchronous |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High in the cycle after a read access |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest situations to reach from the ports are those where service state, pending latches and synchronizer timing interact:
- a second claim while the winner is still in service;
- an edge pulse that has already gone by the time of the claim;
- a falling-edge source that must ignore a rising edge.

The stimulus builds them deliberately:
- It raises four equal-level sources and then claims repeatedly without completing, which walks down the priority order until the all-ones word comes back.
- It pulses edge sources for a single cycle and claims several cycles later.
- It samples `irq_o` on the two negative edges around the synchronizer delay.

A behavioural reference model compares `irq_o`, `bus_rvalid` and every read word on each clock.

// File: rtl/pic_pkg.sv
// pic_pkg: shared constants and the trigger-mode type for the interrupt controller.
// Assumes byte addressing with 32-bit aligned registers.
package pic_pkg;

    typedef enum logic [1:0] {
        TRIG_LVL_HI = 2'd0,
        TRIG_LVL_LO = 2'd1,
        TRIG_RISE   = 2'd2,
        TRIG_FALL   = 2'd3
    } trig_mode_e;

    localparam int TRIG_W        = 2;
    localparam int PRIO_W        = 8;
    localparam int OFF_EN_SET    = 'h000;
    localparam int OFF_EN_CLR    = 'h004;
    localparam int OFF_CLAIM     = 'h008;
    localparam int OFF_DONE      = 'h00C;
    localparam int OFF_TRIG_BASE = 'h100;
    localparam int OFF_PRIO_BASE = 'h200;

endpackage

// File: rtl/pic_sync.sv
// pic_sync: two-flop synchronizer per input, plus a third stage for edge detection.
// Assumes the inputs are asynchronous and can be captured with two flops.
// lvl is the synchronized level. rise and fall each last one cycle per edge.
module pic_sync #(
    parameter int N = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] stg1_q, stg2_q, stg3_q;

    // Shift the raw inputs through three stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg1_q <= '0;
            stg2_q <= '0;
            stg3_q <= '0;
        end else begin
            stg1_q <= raw;
            stg2_q <= stg1_q;
            stg3_q <= stg2_q;
        end
    end

    assign lvl  = stg2_q;
    assign rise = stg2_q & ~stg3_q;
    assign fall = ~stg2_q & stg3_q;

    AST_RISE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        |rise |=> (rise & $past(rise)) == '0); // R5
    AST_FALL_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        |fall |=> (fall & $past(fall)) == '0); // R5
endmodule

// File: rtl/pic_arbiter.sv
// pic_arbiter: picks, among the requesting sources, the one with the smallest priority value.
// Ties go to the lower index. The search is a single combinational linear pass.
module pic_arbiter #(
    parameter int N    = 20,
    parameter int PW   = 8,
    parameter int ID_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         cand,
    input  logic [N-1:0][PW-1:0] prio,
    output logic                 found,
    output logic [ID_W-1:0]      win_id
);
    logic [PW-1:0] best_p;

    // Linear search: a later source wins only with a strictly smaller value.
    always_comb begin
        found  = 1'b0;
        win_id = '0;
        best_p = '1;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || prio[i] < best_p)) begin
                found  = 1'b1;
                best_p = prio[i];
                win_id = ID_W'(i);
            end
        end
    end

    AST_WIN_IS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> cand[win_id]); // R6

    for (genvar k = 0; k < N; k++) begin : g_chk
        AST_WIN_BEST: assert property (@(posedge clk) disable iff (!rst_n)
            (found && cand[k]) |-> prio[k] >= prio[win_id]); // R6
        AST_WIN_TIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (found && cand[k] && prio[k] == prio[win_id]) |-> win_id <= ID_W'(k)); // R6
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
// prio_irq_ctrl: register-mapped interrupt controller for one processor.
// Each source has a trigger mode, a priority, an enable bit, a pending latch and an in-service bit.
// Assumes NUM_SRC <= DATA_W (the enable bitmap fits one word) and DATA_W = 32.
// Each bus access is one cycle. Read data is registered and returns one cycle later.
module prio_irq_ctrl #(
    parameter int NUM_SRC = 20,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_rvalid,
    output logic               irq_o
);
    import pic_pkg::*;

    localparam int ID_W          = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int TRIG_PER_WORD = DATA_W / TRIG_W;
    localparam int PRIO_PER_WORD = DATA_W / PRIO_W;

    logic [NUM_SRC-1:0][TRIG_W-1:0] trig_q;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
    logic [NUM_SRC-1:0] en_q, pend_q, act_q;
    logic [NUM_SRC-1:0] lvl, rise, fall;
    logic [NUM_SRC-1:0] req, edge_seen, claim_fire, done_hit;
    logic               found;
    logic [ID_W-1:0]    win_id;
    logic               wr_acc, rd_acc, claim_rd;
    logic [DATA_W-1:0]  rd_word;

    assign wr_acc   = bus_valid && bus_write;
    assign rd_acc   = bus_valid && !bus_write;
    assign claim_rd = rd_acc && (bus_addr == ADDR_W'(OFF_CLAIM));

    pic_sync #(.N(NUM_SRC)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .raw (irq_in),
        .lvl (lvl),
        .rise (rise),
        .fall (fall)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int TWORD = i / TRIG_PER_WORD;
        localparam int TBIT  = (TRIG_W * i) % DATA_W;
        localparam int PWORD = i / PRIO_PER_WORD;
        localparam int PBIT  = (PRIO_W * i) % DATA_W;

        logic trig_hit, prio_hit, set_hit, clr_hit;

        assign trig_hit = wr_acc && (bus_addr == ADDR_W'(OFF_TRIG_BASE + 4 * TWORD));
        assign prio_hit = wr_acc && (bus_addr == ADDR_W'(OFF_PRIO_BASE + 4 * PWORD));
        assign set_hit  = wr_acc && (bus_addr == ADDR_W'(OFF_EN_SET)) && (bus_wdata == DATA_W'(i));
        assign clr_hit  = wr_acc && (bus_addr == ADDR_W'(OFF_EN_CLR)) && (bus_wdata == DATA_W'(i));
        assign done_hit[i]   = wr_acc && (bus_addr == ADDR_W'(OFF_DONE)) && (bus_wdata == DATA_W'(i));
        assign claim_fire[i] = claim_rd && found && (win_id == ID_W'(i));
        assign edge_seen[i]  = ((trig_q[i] == TRIG_RISE) && rise[i]) ||
                               ((trig_q[i] == TRIG_FALL) && fall[i]);
        assign req[i] = en_q[i] && !act_q[i] &&
                        (trig_q[i][1] ? pend_q[i] : (lvl[i] ^ trig_q[i][0]));

        // Load this source's trigger field from its own word only.
        always_ff @(posedge clk) begin
            if (!rst_n)        trig_q[i] <= TRIG_LVL_HI;
            else if (trig_hit) trig_q[i] <= bus_wdata[TBIT +: TRIG_W];
        end

        // Load this source's priority field from its own word only.
        always_ff @(posedge clk) begin
            if (!rst_n)        prio_q[i] <= '0;
            else if (prio_hit) prio_q[i] <= bus_wdata[PBIT +: PRIO_W];
        end

        // Enable bit: set and clear by source number.
        always_ff @(posedge clk) begin
            if (!rst_n)       en_q[i] <= 1'b0;
            else if (set_hit) en_q[i] <= 1'b1;
            else if (clr_hit) en_q[i] <= 1'b0;
        end

        // In-service bit: set on claim, cleared on completion.
        always_ff @(posedge clk) begin
            if (!rst_n)             act_q[i] <= 1'b0;
            else if (claim_fire[i]) act_q[i] <= 1'b1;
            else if (done_hit[i])   act_q[i] <= 1'b0;
        end

        // Pending latch for edge modes; a new edge wins over a claim in the same cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) pend_q[i] <= 1'b0;
            else        pend_q[i] <= edge_seen[i] || (pend_q[i] && !claim_fire[i]);
        end

        AST_CLAIM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (act_q[i] && !done_hit[i]) |=> act_q[i]); // R7
        AST_CLAIM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            claim_fire[i] |=> act_q[i]); // R7
        AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_seen[i] && !claim_fire[i]) |=> pend_q[i]); // R5
    end

    pic_arbiter #(.N(NUM_SRC), .PW(PRIO_W), .ID_W(ID_W)) u_arb (
        .clk (clk),
        .rst_n (rst_n),
        .cand (req),
        .prio (prio_q),
        .found (found),
        .win_id (win_id)
    );

    // Read multiplexer: build the word for the addressed register.
    always_comb begin
        rd_word = '0;
        if (bus_addr == ADDR_W'(OFF_EN_SET)) begin
            for (int j = 0; j < NUM_SRC; j++) rd_word[j] = en_q[j];
        end else if (bus_addr == ADDR_W'(OFF_CLAIM)) begin
            rd_word = found ? DATA_W'(win_id) : '1;
        end
        for (int i = 0; i < NUM_SRC; i++) begin
            if (bus_addr == ADDR_W'(OFF_TRIG_BASE + 4 * (i / TRIG_PER_WORD)))
                rd_word[(TRIG_W * i) % DATA_W +: TRIG_W] = trig_q[i];
            if (bus_addr == ADDR_W'(OFF_PRIO_BASE + 4 * (i / PRIO_PER_WORD)))
                rd_word[(PRIO_W * i) % DATA_W +: PRIO_W] = prio_q[i];
        end
    end

    // Register read data one cycle after the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd_acc;
            if (rd_acc) bus_rdata <= rd_word;
        end
    end

    assign irq_o = found;

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> bus_rvalid); // R6
    AST_EMPTY_CLAIM_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_rd && !found) |=> (bus_rdata == '1)); // R8
    AST_EMPTY_NO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_rd && !found && !wr_acc) |=> $stable(act_q)); // R8
endmodule

// File: tb/prio_irq_ctrl_test.sv
// prio_irq_ctrl_test: directed stimulus plus a behavioural reference model compared on every clock.
module prio_irq_ctrl_test;
    localparam int NS = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_in = '0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic          irq_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    prio_irq_ctrl #(.NUM_SRC(NS), .ADDR_W(12), .DATA_W(32)) uut (
        .clk (clk),
        .rst_n (rst_n),
        .irq_in (irq_in),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .irq_o (irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int   m_trig [NS];
    int   m_prio [NS];
    bit   m_en [NS], m_pend [NS], m_act [NS];
    bit   m_s1 [NS], m_s2 [NS], m_s3 [NS];
    bit   m_live = 0;
    bit   exp_rvalid = 0;
    logic [31:0] exp_rdata = '0;
    string exp_tag = "";

    function automatic bit m_req(int i);
        bit lv;
        if (!m_en[i] || m_act[i]) return 0;
        if (m_trig[i] >= 2) return m_pend[i];
        lv = (m_trig[i] == 0) ? m_s2[i] : !m_s2[i];
        return lv;
    endfunction

    function automatic int m_winner();
        int w = -1;
        for (int i = 0; i < NS; i++)
            if (m_req(i) && (w < 0 || m_prio[i] < m_prio[w])) w = i;
        return w;
    endfunction

    function automatic logic [31:0] m_read(int a);
        logic [31:0] d = '0;
        int w;
        if (a == 'h000) for (int i = 0; i < NS; i++) d[i] = m_en[i];
        if (a == 'h008) begin
            w = m_winner();
            d = (w < 0) ? 32'hFFFF_FFFF : 32'(w);
        end
        for (int i = 0; i < NS; i++) begin
            if (a == 'h100 + 4 * (i / 16)) d[(2 * i) % 32 +: 2] = 2'(m_trig[i]);
            if (a == 'h200 + 4 * (i / 4))  d[(8 * i) % 32 +: 8] = 8'(m_prio[i]);
        end
        return d;
    endfunction

    function automatic string m_tag(int a);
        if (a == 'h008) return "R6/R8 claim";
        if (a == 'h000) return "R4 enable";
        if (a >= 'h200) return "R3 prio";
        if (a >= 'h100) return "R2 trig";
        return "R1 other";
    endfunction

    always @(posedge clk) begin
        bit edg [NS];
        int claimed, a, v;
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) begin
                m_trig[i] = 0; m_prio[i] = 0; m_en[i] = 0; m_pend[i] = 0; m_act[i] = 0;
                m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0;
            end
            exp_rvalid = 0;
            m_live = 1;
        end else begin
            claimed = -1;
            a = int'(bus_addr);
            v = int'(bus_wdata);
            for (int i = 0; i < NS; i++)
                edg[i] = (m_trig[i] == 2 && m_s2[i] && !m_s3[i]) ||
                         (m_trig[i] == 3 && !m_s2[i] && m_s3[i]);
            exp_rvalid = bus_valid && !bus_write;
            if (exp_rvalid) begin
                exp_rdata = m_read(a);
                exp_tag = m_tag(a);
                if (a == 'h008) claimed = m_winner();
            end
            if (claimed >= 0) m_act[claimed] = 1;
            if (bus_valid && bus_write) begin
                for (int i = 0; i < NS; i++) begin
                    if (a == 'h100 + 4 * (i / 16)) m_trig[i] = int'(bus_wdata[(2 * i) % 32 +: 2]);
                    if (a == 'h200 + 4 * (i / 4))  m_prio[i] = int'(bus_wdata[(8 * i) % 32 +: 8]);
                end
                if (bus_wdata < 32'(NS)) begin
                    if (a == 'h000) m_en[v] = 1;
                    if (a == 'h004) m_en[v] = 0;
                    if (a == 'h00C) m_act[v] = 0;
                end
            end
            for (int i = 0; i < NS; i++) begin
                m_pend[i] = edg[i] || (m_pend[i] && claimed != i);
                m_s3[i] = m_s2[i];
                m_s2[i] = m_s1[i];
                m_s1[i] = irq_in[i];
            end
        end
    end

    // Compare the model with the outputs away from the active edge.
    always @(negedge clk) begin
        if (m_live && rst_n) begin
            chk("R9 irq_o vs model", 32'(irq_o), 32'(m_winner() >= 0));
            chk("R6 rvalid vs model", 32'(bus_rvalid), 32'(exp_rvalid));
            if (exp_rvalid) chk({exp_tag, " rdata vs model"}, bus_rdata, exp_rdata);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 12'(a); bus_wdata = 32'(d);
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = 12'(a);
        @(negedge clk);
        bus_valid = 0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            summary();
        end
    end

    logic [31:0] d;

    initial begin
        idle(3);
        chk("R1 irq_o in reset", 32'(irq_o), 32'd0);
        rst_n = 1;
        rd('h100, d); chk("R1 trig word0 reset", d, 32'h0);
        rd('h000, d); chk("R1 enable reset", d, 32'h0);
        rd('h008, d); chk("R8 empty claim after reset", d, 32'hFFFF_FFFF);

        // Priority packing and word isolation
        wr('h200, 32'h4010_1080);
        rd('h200, d); chk("R3 prio word0 readback", d, 32'h4010_1080);
        wr('h210, 32'h0505_0505);
        rd('h210, d); chk("R3 prio word4 readback", d, 32'h0505_0505);
        rd('h200, d); chk("R3 prio word0 untouched", d, 32'h4010_1080);

        // Trigger packing: word1 holds only sources 16..19
        wr('h104, 32'hFFFF_FFFF);
        rd('h104, d); chk("R2 trig word1 unused bits zero", d, 32'h0000_00FF);
        rd('h100, d); chk("R2 trig word0 untouched", d, 32'h0);
        wr('h104, 32'h0000_0008);   // source 17 rising edge
        rd('h104, d); chk("R2 trig word1 src17 rising", d, 32'h8);

        // Enables, with an out-of-range number ignored
        for (int i = 0; i < 4; i++) wr('h000, i);
        wr('h000, 20);
        rd('h000, d); chk("R4 enable bitmap", d, 32'hF);

        // Level-high arbitration: prio 0x80,0x10,0x10,0x40
        irq_in[3:0] = 4'hF;
        idle(3);
        rd('h008, d); chk("R6 tie goes to lower number", d, 32'd1);
        rd('h008, d); chk("R7 claimed source skipped", d, 32'd2);
        rd('h008, d); chk("R6 next priority", d, 32'd3);
        rd('h008, d); chk("R6 worst priority last", d, 32'd0);
        rd('h008, d); chk("R8 all in service", d, 32'hFFFF_FFFF);
        chk("R9 irq_o low when all in service", 32'(irq_o), 32'd0);
        wr('h00C, 1);
        chk("R7 completion re-arms", 32'(irq_o), 32'd1);
        rd('h008, d); chk("R7 reclaim after completion", d, 32'd1);
        wr('h00C, 25);
        for (int i = 0; i < 4; i++) wr('h004, i);
        for (int i = 0; i < 4; i++) wr('h00C, i);
        rd('h000, d); chk("R4 clear enable", d, 32'h0);
        rd('h008, d); chk("R4 disabled sources not served", d, 32'hFFFF_FFFF);

        // Level-low on source 5
        irq_in[5] = 1;
        wr('h100, 32'h0000_0400);
        wr('h000, 5);
        idle(3);
        rd('h008, d); chk("R5 level-low idle at high", d, 32'hFFFF_FFFF);
        irq_in[5] = 0;
        idle(3);
        rd('h008, d); chk("R5 level-low asserted", d, 32'd5);
        wr('h004, 5);
        wr('h00C, 5);

        // Rising edge on source 17: one-cycle pulse
        wr('h000, 17);
        @(negedge clk); irq_in[17] = 1;
        @(negedge clk); irq_in[17] = 0;
        idle(4);
        rd('h008, d); chk("R5 rising pulse latched", d, 32'd17);
        wr('h00C, 17);
        idle(2);
        rd('h008, d); chk("R7 claim cleared pending", d, 32'hFFFF_FFFF);

        // Falling edge on source 18
        wr('h104, 32'h0000_0038);
        wr('h000, 18);
        irq_in[18] = 1;
        idle(4);
        rd('h008, d); chk("R5 falling ignores rise", d, 32'hFFFF_FFFF);
        irq_in[18] = 0;
        idle(4);
        rd('h008, d); chk("R5 falling edge latched", d, 32'd18);

        // Synchronizer latency on source 19 (level high)
        wr('h000, 19);
        chk("R9 irq_o low before input", 32'(irq_o), 32'd0);
        irq_in[19] = 1;
        @(negedge clk); chk("R5 not visible after one edge", 32'(irq_o), 32'd0);
        @(negedge clk); chk("R5 visible after two edges", 32'(irq_o), 32'd1);
        rd('h008, d); chk("R6 source 19 claimed", d, 32'd19);

        // Priority reprogramming changes the winner
        wr('h00C, 18);
        wr('h00C, 19);
        irq_in[16] = 1;
        wr('h000, 16);
        idle(3);
        rd('h008, d); chk("R6 tie 16 vs 19", d, 32'd16);
        wr('h00C, 16);
        wr('h210, 32'h0105_0505);
        rd('h008, d); chk("R6 smaller value wins", d, 32'd19);

        // Reset in mid-run
        @(negedge clk); rst_n = 0;
        idle(2);
        chk("R1 irq_o low in reset", 32'(irq_o), 32'd0);
        rst_n = 1;
        rd('h000, d); chk("R1 enable cleared", d, 32'h0);
        rd('h200, d); chk("R1 prio cleared", d, 32'h0);
        rd('h104, d); chk("R1 trig cleared", d, 32'h0);
        idle(3);
        summary();
    end
endmodule